// File: doc/BRIEF.md
# Snooping Victim Write Buffer

This block sits between a write-back cache and the shared memory bus. When a dirty line has to leave the cache because a conflicting miss needs its slot, the cache pushes the line's address and data here. The miss fill can then use the bus first, and the dirty line waits in the buffer. Held lines go out to memory when the bus reports itself idle. They also go out when the buffer is full and another eviction is waiting.

While a line sits in the buffer it is still the only dirty copy in the system. For that reason every snooped read and read-for-ownership is compared against the buffered addresses. A hit raises a dirty response, which tells the requester to back off. The hit also marks the entry for an urgent write to memory, and that write is scheduled ahead of the ordinary drain. Snoops of both kinds are handled the same way: the line is written back and its entry is freed.

If the local processor touches a buffered line again before it has drained, a lookup hands the data straight back to the cache and frees the entry, with no memory traffic. A reclaim is refused when a snoop hits the same entry in the same cycle, when the entry is already marked for an urgent write, or when its memory write is in progress. In those cases the cache must retry.

Top module: `victim_buf`

## Requirements
- R1: `evict_ready_o` is high exactly when at least one of the DEPTH (default 4) entries is free. An eviction is stored when `evict_valid_i` and `evict_ready_o` are both high at a clock edge.
- R2: When no entry is marked urgent and `bus_idle_i` is high, the oldest held entry is written to memory. Entries drain in the order they were evicted. No write starts while the bus is busy, the buffer is not full, and nothing is urgent.
- R3: `mem_req_o` keeps `mem_addr_o` and `mem_data_o` stable until a cycle with `mem_gnt_i` high. That grant frees the entry, and `mem_req_o` is low in the following cycle.
- R4: `snp_dirty_o` is high in the same cycle as a valid snoop whose address matches a held line, including a line whose memory write is in progress. It is never high without `snp_valid_i`.
- R5: A snoop hit marks its entry urgent. The urgent entry is written to memory before any idle-time drain and whether or not the bus is idle, with the request rising two cycles after the snoop. Once the write is granted, later snoops of that address miss.
- R6: A lookup that matches a held line which is not blocked raises `lookup_hit_o` with that line's data in the same cycle. It frees the entry and causes no memory request.
- R7: A lookup matching a line that a same-cycle snoop hits, that is marked urgent, or that is being written raises `lookup_wait_o` and not `lookup_hit_o`. The line stays held.
- R8: When all entries are full and `evict_valid_i` is high, the oldest entry is written to memory even while `bus_idle_i` is low.
- R9: After reset the buffer is empty: `evict_ready_o` high, `mem_req_o` low, `snp_dirty_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Cache offers a dirty victim line |
| evict_addr_i | input | ADDR_W | Line address of the victim |
| evict_data_i | input | DATA_W | Line data of the victim |
| evict_ready_o | output | 1 | A free entry exists |
| lookup_valid_i | input | 1 | Local re-access probe |
| lookup_addr_i | input | ADDR_W | Line address of the probe |
| lookup_hit_o | output | 1 | Line handed back to the cache and freed |
| lookup_wait_o | output | 1 | Line held but not reclaimable now; retry |
| lookup_data_o | output | DATA_W | Data of the reclaimed line |
| snp_valid_i | input | 1 | Snooped read or read-exclusive |
| snp_addr_i | input | ADDR_W | Line address of the snoop |
| snp_dirty_o | output | 1 | Line held dirty here; requester must wait |
| bus_idle_i | input | 1 | Data bus has spare bandwidth |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | DATA_W | Write data |
| mem_gnt_i | input | 1 | Memory accepts the write this cycle |

## Verification
On every cycle the assertions check that a pending write holds its address and data until granted, and that the request drops after a grant. They also check that the dirty response never appears without a snoop and covers a line in mid-write. A same-address snoop must always beat a reclaim, and a grant on a full buffer must reopen it. Oldest-first drain order, the precedence of urgent writes over idle drains, and the forced drain on a full buffer depend on the history of evictions. Those are shown only by the bench's directed scenarios. Its random phase compares every write, reclaim and snoop response against a set model of held lines.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic [1:0] {
    DR_NONE  = 2'd0,
    DR_SNOOP = 2'd1,
    DR_IDLE  = 2'd2,
    DR_FULL  = 2'd3
  } drain_cause_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [W-1:0]        key_i,
  input  logic                en_i,
  input  logic [N-1:0][W-1:0] tag_i,
  input  logic [N-1:0]        vld_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = en_i && vld_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [IW-1:0]       alloc_idx_i,
  output logic [N-1:0][N-1:0] older_o
);
  // older_q[i][j]: entry i was allocated before entry j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (alloc_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == alloc_idx_i) older_q[i] <= '0;
        else older_q[i][alloc_idx_i] <= 1'b1;
      end
    end
  end

  assign older_o = older_q;
endmodule

// File: rtl/vb_oldest.sv
module vb_oldest #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]        mask_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic                any_o,
  output logic [IW-1:0]       idx_o
);
  logic [N-1:0] cand;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cand[i] = mask_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && mask_i[j] && !older_i[i][j]) cand[i] = 1'b0;
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  output logic              evict_ready_o,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic              lookup_wait_o,
  output logic [DATA_W-1:0] lookup_data_o,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_dirty_o,
  input  logic              bus_idle_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_gnt_i
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             valid_q, force_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic                         busy_q;
  logic [IW-1:0]                busy_idx_q;

  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [DEPTH-1:0] snp_hit, lk_hit, busy_mask, blocked, reclaim;
  logic [DEPTH-1:0] cand_urgent, cand_all;
  logic             full, accept, done, start;
  logic [IW-1:0]    free_idx, urg_idx, old_idx, start_idx;
  logic             urg_any, old_any;
  drain_cause_e     cause;

  vb_match #(.N(DEPTH), .W(ADDR_W)) u_snp_match (
    .key_i(snp_addr_i), .en_i(snp_valid_i), .tag_i(addr_q),
    .vld_i(valid_q), .hit_o(snp_hit)
  );

  vb_match #(.N(DEPTH), .W(ADDR_W)) u_lk_match (
    .key_i(lookup_addr_i), .en_i(lookup_valid_i), .tag_i(addr_q),
    .vld_i(valid_q), .hit_o(lk_hit)
  );

  always_comb begin
    busy_mask = '0;
    if (busy_q) busy_mask[busy_idx_q] = 1'b1;
  end

  // snoop in the same cycle, pending urgent write or active write all block reclaim
  assign blocked       = snp_hit | force_q | busy_mask;
  assign reclaim       = lk_hit & ~blocked;
  assign lookup_hit_o  = |reclaim;
  assign lookup_wait_o = |(lk_hit & blocked);
  assign snp_dirty_o   = |snp_hit;

  always_comb begin
    lookup_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (reclaim[i]) lookup_data_o = lookup_data_o | data_q[i];
    end
  end

  assign full          = &valid_q;
  assign evict_ready_o = ~full;
  assign accept        = evict_valid_i & ~full;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IW'(i);
    end
  end

  vb_age #(.N(DEPTH), .IW(IW)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_i(accept),
    .alloc_idx_i(free_idx), .older_o(older)
  );

  assign cand_urgent = force_q & valid_q & ~reclaim;
  assign cand_all    = valid_q & ~reclaim;

  vb_oldest #(.N(DEPTH), .IW(IW)) u_old_urgent (
    .mask_i(cand_urgent), .older_i(older), .any_o(urg_any), .idx_o(urg_idx)
  );

  vb_oldest #(.N(DEPTH), .IW(IW)) u_old_all (
    .mask_i(cand_all), .older_i(older), .any_o(old_any), .idx_o(old_idx)
  );

  always_comb begin
    cause     = DR_NONE;
    start_idx = old_idx;
    if (!busy_q) begin
      if (urg_any) begin
        cause     = DR_SNOOP;
        start_idx = urg_idx;
      end else if (old_any && bus_idle_i) begin
        cause = DR_IDLE;
      end else if (old_any && full && evict_valid_i) begin
        cause = DR_FULL;
      end
    end
  end

  assign start = (cause != DR_NONE);
  assign done  = busy_q & mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      force_q    <= '0;
      busy_q     <= 1'b0;
      busy_idx_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (done && busy_idx_q == IW'(i)) begin
          valid_q[i] <= 1'b0;
          force_q[i] <= 1'b0;
        end else if (reclaim[i]) begin
          valid_q[i] <= 1'b0;
        end else if (snp_hit[i]) begin
          force_q[i] <= 1'b1;
        end else if (accept && free_idx == IW'(i)) begin
          valid_q[i] <= 1'b1;
          force_q[i] <= 1'b0;
        end
      end
      if (done) begin
        busy_q <= 1'b0;
      end else if (start) begin
        busy_q     <= 1'b1;
        busy_idx_q <= start_idx;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      addr_q[free_idx] <= evict_addr_i;
      data_q[free_idx] <= evict_data_i;
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q[busy_idx_q];
  assign mem_data_o = data_q[busy_idx_q];
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_ready_o,
  input logic              lookup_valid_i,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              lookup_hit_o,
  input logic              lookup_wait_o,
  input logic              snp_valid_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_dirty_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_gnt_i
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_req_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o);

  p_dirty_needs_snoop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_dirty_o);

  p_draining_dirty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && snp_valid_i && snp_addr_i == mem_addr_o |-> snp_dirty_o);

  p_snoop_beats_reclaim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && lookup_valid_i && snp_addr_i == lookup_addr_i && snp_dirty_o
    |-> !lookup_hit_o && lookup_wait_o);

  p_hit_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> lookup_valid_i && !lookup_wait_o);

  p_grant_frees_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_ready_o && mem_req_o && mem_gnt_i |=> evict_ready_o);
endmodule

bind victim_buf vb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/victim_buf_test.sv
`timescale 1ns / 1ps
module victim_buf_test;
  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int DW    = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          evict_valid_i = 1'b0;
  logic [AW-1:0] evict_addr_i = '0;
  logic [DW-1:0] evict_data_i = '0;
  logic          evict_ready_o;
  logic          lookup_valid_i = 1'b0;
  logic [AW-1:0] lookup_addr_i = '0;
  logic          lookup_hit_o, lookup_wait_o;
  logic [DW-1:0] lookup_data_o;
  logic          snp_valid_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          snp_dirty_o;
  logic          bus_idle_i = 1'b0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;
  logic          mem_gnt_i = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [logic [AW-1:0]];

  victim_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [DW-1:0] dat_of(logic [AW-1:0] a);
    return {a ^ 32'h5a5a_0000, ~a};
  endfunction

  function automatic logic [AW-1:0] adr(int k);
    return 32'h0000_0100 + AW'(k) * 32'h40;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push(logic [AW-1:0] a);
    evict_valid_i = 1'b1;
    evict_addr_i  = a;
    evict_data_i  = dat_of(a);
    step();
    evict_valid_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(evict_ready_o == 1'b1, "R9 ready", 64'(evict_ready_o), 1);
    chk(mem_req_o == 1'b0, "R9 req", 64'(mem_req_o), 0);
    chk(snp_dirty_o == 1'b0, "R9 dirty", 64'(snp_dirty_o), 0);

    // fill with bus busy
    for (int k = 0; k < 4; k++) push(adr(k));
    chk(evict_ready_o == 1'b0, "R1 full", 64'(evict_ready_o), 0);
    chk(mem_req_o == 1'b0, "R2 no drain while busy", 64'(mem_req_o), 0);

    // full with pending eviction forces a drain of the oldest
    evict_valid_i = 1'b1; evict_addr_i = adr(4); evict_data_i = dat_of(adr(4));
    step();
    chk(mem_req_o && mem_addr_o == adr(0), "R8 forced drain addr", 64'(mem_addr_o), 64'(adr(0)));
    chk(mem_data_o == dat_of(adr(0)), "R8 forced drain data", mem_data_o, dat_of(adr(0)));
    mem_gnt_i = 1'b1;
    step();
    mem_gnt_i = 1'b0;
    chk(mem_req_o == 1'b0, "R3 req drops", 64'(mem_req_o), 0);
    chk(evict_ready_o == 1'b1, "R1 slot freed", 64'(evict_ready_o), 1);
    step();
    evict_valid_i = 1'b0;
    chk(evict_ready_o == 1'b0, "R1 refilled", 64'(evict_ready_o), 0);

    // snoop hit: urgent write ahead of idle drain of oldest (adr1)
    snp_valid_i = 1'b1; snp_addr_i = adr(3);
    #1 chk(snp_dirty_o == 1'b1, "R4 snoop hit", 64'(snp_dirty_o), 1);
    step();
    snp_valid_i = 1'b0;
    bus_idle_i = 1'b1;
    step();
    chk(mem_req_o && mem_addr_o == adr(3), "R5 urgent first", 64'(mem_addr_o), 64'(adr(3)));
    snp_valid_i = 1'b1; snp_addr_i = adr(3);
    lookup_valid_i = 1'b1; lookup_addr_i = adr(3);
    #1 chk(snp_dirty_o == 1'b1, "R4 dirty while draining", 64'(snp_dirty_o), 1);
    chk(lookup_wait_o && !lookup_hit_o, "R7 draining not reclaimable", 64'(lookup_hit_o), 0);
    snp_valid_i = 1'b0; lookup_valid_i = 1'b0;
    mem_gnt_i = 1'b1;
    step();
    mem_gnt_i = 1'b0; bus_idle_i = 1'b0;
    snp_valid_i = 1'b1; snp_addr_i = adr(3);
    #1 chk(snp_dirty_o == 1'b0, "R5 freed after flush", 64'(snp_dirty_o), 0);
    chk(mem_req_o == 1'b0, "R3 idle after grant", 64'(mem_req_o), 0);
    snp_valid_i = 1'b0;

    // reclaim
    lookup_valid_i = 1'b1; lookup_addr_i = adr(2);
    #1 chk(lookup_hit_o && !lookup_wait_o, "R6 reclaim hit", 64'(lookup_hit_o), 1);
    chk(lookup_data_o == dat_of(adr(2)), "R6 reclaim data", lookup_data_o, dat_of(adr(2)));
    step();
    #1 chk(!lookup_hit_o && !lookup_wait_o, "R6 entry gone", 64'(lookup_hit_o), 0);
    chk(mem_req_o == 1'b0, "R6 no memory traffic", 64'(mem_req_o), 0);
    lookup_valid_i = 1'b0;

    // same-cycle snoop and reclaim on adr4
    lookup_valid_i = 1'b1; lookup_addr_i = adr(4);
    snp_valid_i = 1'b1; snp_addr_i = adr(4);
    #1 chk(lookup_wait_o && !lookup_hit_o, "R7 snoop wins", 64'(lookup_hit_o), 0);
    chk(snp_dirty_o == 1'b1, "R7 dirty reported", 64'(snp_dirty_o), 1);
    step();
    snp_valid_i = 1'b0;
    #1 chk(lookup_wait_o && !lookup_hit_o, "R7 urgent not reclaimable", 64'(lookup_hit_o), 0);
    lookup_valid_i = 1'b0;
    step();
    chk(mem_req_o && mem_addr_o == adr(4), "R5 urgent with bus busy", 64'(mem_addr_o), 64'(adr(4)));
    mem_gnt_i = 1'b1;
    step();
    mem_gnt_i = 1'b0;

    // oldest-first idle drain: adr1, adr5, adr6
    push(adr(5));
    push(adr(6));
    bus_idle_i = 1'b1; mem_gnt_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      logic [AW-1:0] exp_a;
      exp_a = (k == 0) ? adr(1) : adr(4 + k);
      for (int w = 0; w < 8 && !mem_req_o; w++) step();
      chk(mem_req_o && mem_addr_o == exp_a, "R2 drain order", 64'(mem_addr_o), 64'(exp_a));
      step();
    end
    bus_idle_i = 1'b0; mem_gnt_i = 1'b0;
    step();
    chk(evict_ready_o && !mem_req_o, "R2 drained empty", 64'(mem_req_o), 0);

    // random phase against a set model
    begin
      int next_a = 64;
      for (int cyc = 0; cyc < 3000; cyc++) begin
        evict_valid_i  = ($urandom_range(9) < 4);
        evict_addr_i   = adr(next_a);
        evict_data_i   = dat_of(adr(next_a));
        lookup_valid_i = ($urandom_range(9) < 2);
        lookup_addr_i  = adr(next_a - 1 - int'($urandom_range(7)));
        snp_valid_i    = ($urandom_range(9) < 2);
        snp_addr_i     = adr(next_a - 1 - int'($urandom_range(7)));
        bus_idle_i     = ($urandom_range(9) < 3);
        mem_gnt_i      = $urandom_range(1) == 1;
        #1;
        chk(evict_ready_o == (model.num() < DEPTH), "R1 ready vs count",
            64'(evict_ready_o), 64'(model.num() < DEPTH));
        chk(snp_dirty_o == (snp_valid_i && model.exists(snp_addr_i)), "R4 snoop response",
            64'(snp_dirty_o), 64'(snp_valid_i && model.exists(snp_addr_i)));
        chk((lookup_hit_o | lookup_wait_o) == (lookup_valid_i && model.exists(lookup_addr_i)),
            "R6 lookup match", 64'(lookup_hit_o | lookup_wait_o), 64'(model.exists(lookup_addr_i)));
        if (snp_valid_i && lookup_valid_i && snp_addr_i == lookup_addr_i && snp_dirty_o)
          chk(!lookup_hit_o, "R7 random snoop wins", 64'(lookup_hit_o), 0);
        if (mem_req_o) begin
          chk(model.exists(mem_addr_o) && model[mem_addr_o] == mem_data_o, "R3 write data",
              mem_data_o, dat_of(mem_addr_o));
          if (mem_gnt_i) model.delete(mem_addr_o);
        end
        if (lookup_hit_o) begin
          chk(model.exists(lookup_addr_i) && lookup_data_o == model[lookup_addr_i],
              "R6 reclaim data", lookup_data_o, dat_of(lookup_addr_i));
          model.delete(lookup_addr_i);
        end
        if (evict_valid_i && evict_ready_o) begin
          model[evict_addr_i] = evict_data_i;
          next_a++;
        end
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial process::self().srandom(32'd1234);
endmodule